// File: doc/BRIEF.md
# In-Order Read Response Router

This block connects one read-issuing master to several memory-mapped slaves over the AXI4 read address and read data channels. Each incoming read address is sent to exactly one slave. The slave is picked from the uppermost address bits, and the address space is split into equal regions. Address, ID and burst length go to every slave unchanged, so a single master may use one ID for all of its reads. Only the chosen slave sees ARVALID.

Read data must come back in the same order as the reads were accepted, even when a later read targets a faster slave. The router keeps a queue of slave indices, one entry per accepted read, in acceptance order. Only the slave at the head of that queue is connected to the master's R channel. Every other slave has its RREADY held low, so a slave that finishes early waits until all older bursts have been fully delivered. No response data is stored inside the router.

Top module: `rd_order_router`

## Requirements
- R1: A read address with ARVALID high goes to slave number `mArAddr[ADDR_W-1 -: log2(N_SLV)]`. Only that bit of `sArValid` is 1, and all other bits are 0.
- R2: When the queue is not full, `mArReady` equals the ARREADY of the decoded slave and ignores the ARREADY of every other slave.
- R3: With DEPTH reads outstanding, `mArReady` is 0 and every bit of `sArValid` is 0, whatever the slaves' ARREADY values are.
- R4: `mRValid`, `mRData`, `mRId`, `mRResp` and `mRLast` are copied from the slave that owns the oldest outstanding read.
- R5: The oldest read's slave receives `mRReady` on its RREADY, and every other slave's RREADY is 0. A slave that has data before its turn is therefore stalled.
- R6: With no read outstanding, `mRValid` is 0 and every bit of `sRReady` is 0.
- R7: An entry is retired only by an R handshake with RLAST high. A beat with RLAST low leaves the same slave at the head.
- R8: An acceptance and a retirement in the same cycle both take effect, so the number of outstanding reads stays the same.
- R9: `sArAddr`, `sArId` and `sArLen` equal the master's address, ID and length unmodified.
- R10: After reset, no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mArValid | input | 1 | Master read address valid |
| mArReady | output | 1 | Read address ready to master |
| mArAddr | input | ADDR_W | Master read address |
| mArId | input | ID_W | Master read ID |
| mArLen | input | 8 | Master burst length |
| mRValid | output | 1 | Read data valid to master |
| mRReady | input | 1 | Master ready for read data |
| mRData | output | DATA_W | Read data to master |
| mRId | output | ID_W | Read ID to master |
| mRResp | output | 2 | Read response to master |
| mRLast | output | 1 | Last beat of burst to master |
| sArValid | output | N_SLV | Per-slave read address valid |
| sArReady | input | N_SLV | Per-slave read address ready |
| sArAddr | output | ADDR_W | Address broadcast to slaves |
| sArId | output | ID_W | ID broadcast to slaves |
| sArLen | output | 8 | Burst length broadcast to slaves |
| sRValid | input | N_SLV | Per-slave read data valid |
| sRReady | output | N_SLV | Per-slave read data ready |
| sRData | input | N_SLV*DATA_W | Per-slave read data, slave i at bits i*DATA_W |
| sRId | input | N_SLV*ID_W | Per-slave read ID |
| sRResp | input | N_SLV*2 | Per-slave read response |
| sRLast | input | N_SLV | Per-slave last-beat flag |

## Verification
A new read can be accepted in the same cycle that the last beat of the oldest burst is handed to the master. In that cycle the queue both grows and shrinks. The bench first fills the queue, drains one entry to leave a single free slot, and then drives ARVALID to a new slave together with a last R beat from the head slave. It then offers one more read and expects it to be accepted and the next one refused. This only happens if the occupancy stayed the same across the combined cycle. The drain that follows must return the remaining bursts in their original slave order.

// File: rtl/rr_pkg.sv
package rr_pkg;
  // Steering word sent from order control to the response datapath.
  typedef struct packed {
    logic       grant;  // at least one read outstanding
    logic [7:0] head;   // slave index owning the oldest read
  } rrSteer_t;
endpackage

// File: rtl/rr_order_ctrl.sv
module rr_order_ctrl #(
  parameter int N_SLV = 4,
  parameter int DEPTH = 8,
  localparam int SEL_W = $clog2(N_SLV)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mArValid,
  input  logic [SEL_W-1:0] arSel,
  input  logic [N_SLV-1:0] sArReady,
  output logic             mArReady,
  output logic [N_SLV-1:0] sArValid,
  input  logic             rValid,
  input  logic             rReady,
  input  logic             rLast,
  output rr_pkg::rrSteer_t steer
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] FULL_CNT = (PTR_W+1)'(DEPTH);

  logic [SEL_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic full, push, pop;

  assign full = (count == FULL_CNT);

  always_comb begin
    sArValid = '0;
    if (mArValid && !full) sArValid[arSel] = 1'b1;
  end

  assign mArReady = !full && sArReady[arSel];
  assign push     = mArValid && mArReady;
  assign pop      = rValid && rReady && rLast && (count != '0);

  always_ff @(posedge clk) begin
    if (push) slot[wrPtr] <= arSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign steer.grant = (count != '0);
  assign steer.head  = 8'(slot[rdPtr]);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    full |-> (sArValid == '0));
  p_steady_occ_r8: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop) |=> $stable(count));
  p_hold_head_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rReady && !rLast) |=> $stable(rdPtr));
  p_one_target_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sArValid));
endmodule

// File: rtl/rr_resp_path.sv
module rr_resp_path #(
  parameter int N_SLV  = 4,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  rr_pkg::rrSteer_t        steer,
  input  logic                    mRReady,
  output logic                    mRValid,
  output logic [DATA_W-1:0]       mRData,
  output logic [ID_W-1:0]         mRId,
  output logic [1:0]              mRResp,
  output logic                    mRLast,
  input  logic [N_SLV-1:0]        sRValid,
  output logic [N_SLV-1:0]        sRReady,
  input  logic [N_SLV*DATA_W-1:0] sRData,
  input  logic [N_SLV*ID_W-1:0]   sRId,
  input  logic [N_SLV*2-1:0]      sRResp,
  input  logic [N_SLV-1:0]        sRLast
);
  logic [N_SLV-1:0] hit;

  for (genvar i = 0; i < N_SLV; i++) begin : g_hit
    assign hit[i]     = steer.grant && (steer.head == 8'(i));
    assign sRReady[i] = hit[i] && mRReady;
  end

  always_comb begin
    mRValid = 1'b0;
    mRData  = '0;
    mRId    = '0;
    mRResp  = '0;
    mRLast  = 1'b0;
    for (int i = 0; i < N_SLV; i++) begin
      if (hit[i]) begin
        mRValid = sRValid[i];
        mRData  = sRData[i*DATA_W +: DATA_W];
        mRId    = sRId[i*ID_W +: ID_W];
        mRResp  = sRResp[i*2 +: 2];
        mRLast  = sRLast[i];
      end
    end
  end

  p_single_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sRReady));
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !steer.grant |-> (!mRValid && sRReady == '0));
  p_ready_follows_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sRReady != '0) |-> mRReady);
endmodule

// File: rtl/rd_order_router.sv
module rd_order_router #(
  parameter int N_SLV  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int DEPTH  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    mArValid,
  output logic                    mArReady,
  input  logic [ADDR_W-1:0]       mArAddr,
  input  logic [ID_W-1:0]         mArId,
  input  logic [7:0]              mArLen,
  output logic                    mRValid,
  input  logic                    mRReady,
  output logic [DATA_W-1:0]       mRData,
  output logic [ID_W-1:0]         mRId,
  output logic [1:0]              mRResp,
  output logic                    mRLast,
  output logic [N_SLV-1:0]        sArValid,
  input  logic [N_SLV-1:0]        sArReady,
  output logic [ADDR_W-1:0]       sArAddr,
  output logic [ID_W-1:0]         sArId,
  output logic [7:0]              sArLen,
  input  logic [N_SLV-1:0]        sRValid,
  output logic [N_SLV-1:0]        sRReady,
  input  logic [N_SLV*DATA_W-1:0] sRData,
  input  logic [N_SLV*ID_W-1:0]   sRId,
  input  logic [N_SLV*2-1:0]      sRResp,
  input  logic [N_SLV-1:0]        sRLast
);
  localparam int SEL_W = $clog2(N_SLV);

  rr_pkg::rrSteer_t steer;

  // R9: request fields pass through untouched
  assign sArAddr = mArAddr;
  assign sArId   = mArId;
  assign sArLen  = mArLen;

  rr_order_ctrl #(.N_SLV(N_SLV), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .mArValid(mArValid), .arSel(mArAddr[ADDR_W-1 -: SEL_W]),
    .sArReady(sArReady), .mArReady(mArReady), .sArValid(sArValid),
    .rValid(mRValid), .rReady(mRReady), .rLast(mRLast),
    .steer(steer)
  );

  rr_resp_path #(.N_SLV(N_SLV), .DATA_W(DATA_W), .ID_W(ID_W)) u_path (
    .clk(clk), .rstN(rstN), .steer(steer), .mRReady(mRReady),
    .mRValid(mRValid), .mRData(mRData), .mRId(mRId), .mRResp(mRResp),
    .mRLast(mRLast), .sRValid(sRValid), .sRReady(sRReady),
    .sRData(sRData), .sRId(sRId), .sRResp(sRResp), .sRLast(sRLast)
  );
endmodule

// File: tb/rd_order_router_test.sv
module rd_order_router_test;
  logic clk = 1'b0, rstN = 1'b0;
  always #10 clk = ~clk;

  logic        mArValid = 0, mArReady, mRValid, mRReady = 0, mRLast;
  logic [31:0] mArAddr = 0, mRData, sArAddr;
  logic [3:0]  mArId = 0, mRId, sArId, sArValid, sArReady = 0;
  logic [3:0]  sRValid = 0, sRReady, sRLast = 0;
  logic [7:0]  mArLen = 8'd3, sArLen;
  logic [1:0]  mRResp;
  logic [127:0] sRData = {32'hD3, 32'hD2, 32'hD1, 32'hD0};
  logic [15:0]  sRId = 16'h0;
  logic [7:0]   sRResp = {2'd3, 2'd2, 2'd1, 2'd0};

  int nRun = 0, nFail = 0;
  bit done = 0;

  rd_order_router uut (.*);

  // row: {slave[1:0], sArReady[3:0], expReady, expValid[3:0]}
  localparam logic [10:0] AR_TAB [5] = '{
    {2'd2, 4'b1111, 1'b1, 4'b0100},
    {2'd0, 4'b1110, 1'b0, 4'b0001},
    {2'd0, 4'b1111, 1'b1, 4'b0001},
    {2'd3, 4'b0111, 1'b0, 4'b1000},
    {2'd1, 4'b1111, 1'b1, 4'b0010}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setAr(input logic [1:0] slv, input int off);
    mArAddr = {slv, 30'(off)};
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    sRValid = 4'hF; mRReady = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #2;
    chk("R10 empty after reset mRValid", mRValid, 0);
    chk("R6 empty sRReady", sRReady, 0);
    mRReady = 0; sRValid = 0;

    // table walk: AR decode and ready steering
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      mArValid = 1; setAr(AR_TAB[i][10:9], 16 + i * 4); sArReady = AR_TAB[i][8:5];
      #2;
      chk("R1 sArValid", sArValid, AR_TAB[i][3:0]);
      chk("R2 mArReady", mArReady, AR_TAB[i][4]);
      chk("R9 address passthrough", sArAddr, mArAddr);
      chk("R9 id/len passthrough", {sArId, sArLen}, {mArId, mArLen});
    end
    @(posedge clk);
    // queue now holds slaves 2,0,1
    @(negedge clk);
    mArValid = 0; sRValid = 4'hF; sRLast = 4'b1011; mRReady = 0;
    #2;
    chk("R4 head data slave2", mRData, 32'hD2);
    chk("R4 head resp slave2", mRResp, 2);
    chk("R5 no ready while master stalls", sRReady, 0);
    mRReady = 1; #1;
    chk("R5 early slaves stalled", sRReady, 4'b0100);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R7 non-last beat keeps head", mRData, 32'hD2);
    sRLast = 4'hF;
    @(posedge clk);
    @(negedge clk); #2;
    chk("R4 next head slave0", mRData, 32'hD0);
    chk("R5 ready to slave0", sRReady, 4'b0001);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R4 next head slave1", mRData, 32'hD1);
    chk("R5 ready to slave1", sRReady, 4'b0010);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R6 drained mRValid", mRValid, 0);
    chk("R6 drained sRReady", sRReady, 0);

    // fill queue with slave3 reads
    mRReady = 0; mArValid = 1; setAr(2'd3, 0); sArReady = 4'hF;
    repeat (8) @(posedge clk);
    @(negedge clk); #2;
    chk("R3 full mArReady", mArReady, 0);
    chk("R3 full sArValid", sArValid, 0);
    // retire one to leave one free slot
    mArValid = 0; mRReady = 1;
    @(posedge clk);
    @(negedge clk);
    mArValid = 1; setAr(2'd1, 4); #2;
    chk("R8 accept while retiring", mArReady, 1);
    chk("R8 retire while accepting", sRReady, 4'b1000);
    @(posedge clk);
    @(negedge clk);
    mRReady = 0; setAr(2'd2, 8); #2;
    chk("R8 one slot left after combined cycle", mArReady, 1);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R8 full after last slot", mArReady, 0);
    mArValid = 0; mRReady = 1;
    for (int k = 0; k < 6; k++) begin
      chk("R4 drain slave3", mRData, 32'hD3);
      @(posedge clk);
      @(negedge clk); #2;
    end
    chk("R4 drain slave1 after slave3", mRData, 32'hD1);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R4 drain slave2 last", mRData, 32'hD2);
    @(posedge clk);
    @(negedge clk); #2;
    chk("R6 empty at end", {mRValid, sRReady}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule